// File: doc/BRIEF.md
# PWM Output Gate with Synchronized Disable Mask

This block is the last stage of a three-phase, six-output PWM generator and sits after the crossover stage. It takes six raw PWM signals, one high-side and one low-side signal for each of phases A, B and C. It drives six gated outputs. A six-bit disable word chooses which outputs are held in their off state. While an output's bit is set, that output stays off whatever duty cycle produced its raw signal.

Software writes go into a shadow register, and the shadow value is what a read returns. The shadow is copied into the active mask only when a PWM cycle boundary is detected, which is the rising edge of the cycle-start sync input. When double-update mode is selected, the rising edge of the mid-cycle sync input also copies the shadow. Because of this, an enable change never takes effect partway through a pulse. The off level follows the polarity configuration input. Wrong polarity settings can cause shoot-through in the external inverter, so the polarity input comes straight from its configuration bit and is never changed here.

Top module: `pwm_out_gate`

## Requirements
- R1: Each bit of `wr_data`, `rd_shadow`, `active_mask`, `raw_pwm` and `pwm_out` maps to one output as follows: bit0 = phase C low, bit1 = phase C high, bit2 = phase B low, bit3 = phase B high, bit4 = phase A low, bit5 = phase A high.
- R2: When an active-mask bit is 1, its output is held at the off level whatever the value of its raw input.
- R3: The off level is 0 when `pol_active_high` is 1 and 1 when `pol_active_high` is 0.
- R4: When an active-mask bit is 0, its output equals its raw input in the same cycle.
- R5: After reset, both the shadow and the active mask are 0, so every output passes its raw input.
- R6: A write (`wr_en`=1) loads `wr_data` into the shadow, and `rd_shadow` shows it after that clock edge. The active mask does not change unless a commit happens.
- R7: A commit happens on a clock edge where `cycle_sync` is 1 and was 0 on the previous edge. If `cycle_sync` stays high, no further commit happens.
- R8: When `dbl_update` is 1, a rising edge of `mid_sync` also commits. When `dbl_update` is 0, `mid_sync` has no effect.
- R9: If a write and a commit happen on the same edge, the newly written value goes into the active mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| raw_pwm | input | 6 | PWM signals after crossover |
| wr_en | input | 1 | Write strobe for the disable word |
| wr_data | input | 6 | Disable word; 1 = output held off |
| cycle_sync | input | 1 | PWM cycle-start sync |
| mid_sync | input | 1 | PWM mid-cycle sync |
| dbl_update | input | 1 | 1 = double-update mode |
| pol_active_high | input | 1 | 1 = outputs are active high |
| pwm_out | output | 6 | Gated PWM outputs |
| rd_shadow | output | 6 | Read-back of the shadow word |
| active_mask | output | 6 | Disable mask currently in force |

## Verification
The assertions check on every cycle that:
- the active mask changes only when a commit happens;
- a mid-cycle edge in single-update mode leaves the active mask alone;
- a same-cycle write wins over the shadow during a commit;
- a fully masked output word sits at the off level.

The bench's scenarios show the rest:
- the bit-to-output mapping;
- that a sync input held high does not commit again;
- that the off level flips with polarity;
- that unmasked outputs follow their raw inputs.

// File: rtl/pwm_out_gate.sv
module pwm_out_gate #(
  parameter int N_OUT = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_OUT-1:0] raw_pwm,
  input  logic             wr_en,
  input  logic [N_OUT-1:0] wr_data,
  input  logic             cycle_sync,
  input  logic             mid_sync,
  input  logic             dbl_update,
  input  logic             pol_active_high,
  output logic [N_OUT-1:0] pwm_out,
  output logic [N_OUT-1:0] rd_shadow,
  output logic [N_OUT-1:0] active_mask
);

  logic [N_OUT-1:0] shadow_q, active_q, commit_val;
  logic cyc_prev, mid_prev, cyc_rise, mid_rise, commit;
  logic off_lvl;

  assign cyc_rise   = cycle_sync & ~cyc_prev;
  assign mid_rise   = mid_sync & ~mid_prev;
  assign commit     = cyc_rise | (dbl_update & mid_rise);
  assign commit_val = wr_en ? wr_data : shadow_q;
  assign off_lvl    = ~pol_active_high;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc_prev <= 1'b0;
      mid_prev <= 1'b0;
      shadow_q <= '0;
      active_q <= '0;
    end else begin
      cyc_prev <= cycle_sync;
      mid_prev <= mid_sync;
      if (wr_en)  shadow_q <= wr_data;
      if (commit) active_q <= commit_val;
    end
  end

  for (genvar i = 0; i < N_OUT; i++) begin : g_gate
    assign pwm_out[i] = active_q[i] ? off_lvl : raw_pwm[i];
  end

  assign rd_shadow   = shadow_q;
  assign active_mask = active_q;

  assert_mask_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(cycle_sync && !$past(cycle_sync)) && !(mid_sync && !$past(mid_sync))
    |=> $stable(active_mask));

  assert_single_mode_mid_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mid_sync && !dbl_update && (cycle_sync == cyc_prev || !cycle_sync))
    |=> $stable(active_mask));

  assert_write_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && cycle_sync && !cyc_prev) |=> (active_mask == $past(wr_data)));

  assert_shadow_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (rd_shadow == $past(wr_data)));

  assert_all_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (active_mask == {N_OUT{1'b1}}) |-> (pwm_out == {N_OUT{~pol_active_high}}));

endmodule

// File: tb/pwm_out_gate_tb.sv
module pwm_out_gate_tb;
  logic clk = 0, rst_n = 0;
  logic [5:0] raw_pwm = 0, wr_data = 0;
  logic wr_en = 0, cycle_sync = 0, mid_sync = 0, dbl_update = 0, pol_active_high = 1;
  logic [5:0] pwm_out, rd_shadow, active_mask;
  int n_chk = 0, n_bad = 0;

  always #5 clk = ~clk;

  pwm_out_gate u_dut (.clk, .rst_n, .raw_pwm, .wr_en, .wr_data, .cycle_sync,
    .mid_sync, .dbl_update, .pol_active_high, .pwm_out, .rd_shadow, .active_mask);

  task automatic chk(string req, logic [5:0] act, logic [5:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic commit_edge();
    cycle_sync = 1; step(); cycle_sync = 0; step();
  endtask

  task automatic t_reset();
    raw_pwm = 6'h2A;
    #1;
    chk("R5 shadow", rd_shadow, 6'h00);
    chk("R5 active", active_mask, 6'h00);
    chk("R5 pass", pwm_out, 6'h2A);
  endtask

  task automatic t_defer();
    wr_en = 1; wr_data = 6'h05; step(); wr_en = 0;
    chk("R6 shadow", rd_shadow, 6'h05);
    step(); step();
    chk("R6 active held", active_mask, 6'h00);
    chk("R4 pass", pwm_out, 6'h2A);
  endtask

  task automatic t_commit_pol();
    commit_edge();
    chk("R7 commit", active_mask, 6'h05);
    raw_pwm = 6'h3F; pol_active_high = 1; #1;
    chk("R2 forced low", pwm_out, 6'h3A);
    raw_pwm = 6'h00; pol_active_high = 0; #1;
    chk("R3 forced high", pwm_out, 6'h05);
    pol_active_high = 1;
  endtask

  task automatic t_held_sync();
    wr_en = 1; wr_data = 6'h30; cycle_sync = 1; step(); wr_en = 0;
    chk("R9 write wins", active_mask, 6'h30);
    wr_en = 1; wr_data = 6'h0C; step(); wr_en = 0;
    step(); step();
    chk("R7 held high no recommit", active_mask, 6'h30);
    cycle_sync = 0; step(); cycle_sync = 1; step();
    chk("R7 new edge", active_mask, 6'h0C);
    cycle_sync = 0; step();
  endtask

  task automatic t_mid();
    dbl_update = 0;
    wr_en = 1; wr_data = 6'h11; step(); wr_en = 0;
    mid_sync = 1; step(); mid_sync = 0; step();
    chk("R8 single ignores mid", active_mask, 6'h0C);
    dbl_update = 1;
    mid_sync = 1; step(); mid_sync = 0; step();
    chk("R8 double commits mid", active_mask, 6'h11);
    dbl_update = 0;
  endtask

  task automatic t_bitmap();
    raw_pwm = 6'h3F; pol_active_high = 1;
    for (int i = 0; i < 6; i++) begin
      wr_en = 1; wr_data = 6'(1 << i); step(); wr_en = 0;
      commit_edge();
      chk($sformatf("R1 bit%0d", i), pwm_out, ~6'(1 << i));
    end
    wr_en = 1; wr_data = 6'h3F; step(); wr_en = 0;
    commit_edge();
    chk("R2 all off", pwm_out, 6'h00);
    wr_en = 1; wr_data = 6'h00; step(); wr_en = 0;
    commit_edge();
    raw_pwm = 6'h15; #1;
    chk("R4 all pass", pwm_out, 6'h15);
  endtask

  initial begin
    #100000;
    n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    step(); rst_n = 1; step();
    t_defer();
    t_commit_pol();
    t_held_sync();
    t_mid();
    t_bitmap();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule